// File: doc/BRIEF.md
# Packed Lane Shuffle Unit

This execution unit rearranges 32-bit lanes of 128-bit vectors. Each operation supplies two vector operands of four lanes each and an 8-bit control byte. The two low lanes of the result come only from the first operand, and the two high lanes come only from the second operand. Each result lane has its own 2-bit index field in the control byte, so any lane may repeat or be left out. Lane contents are moved as raw bit patterns and are never interpreted as numbers.

Operations are issued with a valid strobe and a tag, and the unit accepts one per clock. The result and the tag come out a fixed number of cycles later, with no stall. A synchronous flush removes every operation still in flight, so a pipeline being redirected can drop work that was issued speculatively. Reset clears the valid pipeline but not the data registers.

Top module: `lane_shuffle_unit`

## Requirements
- R1: Lanes are numbered 0 to 3 from the least significant end. An index value k selects bits 32k+31 down to 32k of its operand. Result lane j takes its index from control bits 2j+1 down to 2j.
- R2: Result lane 0 equals first-operand lane ctrl[1:0], and result lane 1 equals first-operand lane ctrl[3:2].
- R3: Result lane 2 equals second-operand lane ctrl[5:4], and result lane 3 equals second-operand lane ctrl[7:6].
- R4: Lane bit patterns arrive unchanged, including NaN, infinity, signed zero and denormal encodings.
- R5: Each result is computed only from the operand values present in the accepting cycle. This holds when both operands are identical and when the inputs change in later cycles.
- R6: An operation accepted in cycle c (in_valid high at that rising edge) presents out_valid, out_tag and out_result in cycle c+LATENCY, where LATENCY defaults to 3. Back-to-back operations emerge back to back.
- R7: out_valid is low in every cycle that corresponds to an input cycle with in_valid low.
- R8: When flush is high at a rising edge, every operation in flight and the operation offered in that same cycle are discarded. out_valid is then low until operations accepted after the flush arrive.
- R9: While reset is high at a rising edge, out_valid becomes low and all in-flight operations are lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous discard of all in-flight operations |
| in_valid | input | 1 | Operation offered this cycle |
| in_tag | input | TAG_W | Operation tag, passed through |
| in_ctrl | input | 8 | Four 2-bit lane index fields |
| in_opa | input | 128 | First operand, source of the low result lanes |
| in_opb | input | 128 | Second operand, source of the high result lanes |
| out_valid | output | 1 | Result valid |
| out_tag | output | TAG_W | Tag of the result |
| out_result | output | 128 | Shuffled vector |

## Verification
On every accepted operation, the assertions check three things: each lane index decodes to exactly one source lane, every low result lane matches some lane of the first operand, and every high result lane matches some lane of the second operand. On every cycle they also check that no valid result appears in the cycle after a flush, and that no result emerges before a full pipeline depth has passed since the last flush or reset. Only the bench scenarios can show that the correct lane is chosen for each of the 256 control values. The same applies to the exact latency and tag pairing, to gaps in the issue stream, and to special bit patterns passing through unchanged.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;
  localparam int DEF_LANE_W  = 32;
  localparam int DEF_LANES   = 4;
  localparam int DEF_TAG_W   = 4;
  localparam int DEF_LATENCY = 3;
endpackage

// File: rtl/lane_shuffle_decode.sv
module lane_shuffle_decode #(
  parameter int LANES = 4,
  parameter int SEL_W = 2
) (
  input  logic [LANES*SEL_W-1:0]      ctrl,
  output logic [LANES-1:0][LANES-1:0] sel_oh
);
  for (genvar j = 0; j < LANES; j++) begin : g_field
    always_comb begin
      sel_oh[j] = '0;
      for (int k = 0; k < LANES; k++) begin
        if (ctrl[j*SEL_W +: SEL_W] == SEL_W'(k)) sel_oh[j][k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lane_shuffle_mux.sv
module lane_shuffle_mux #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4
) (
  input  logic [LANES*LANE_W-1:0]     opa,
  input  logic [LANES*LANE_W-1:0]     opb,
  input  logic [LANES-1:0][LANES-1:0] sel_oh,
  output logic [LANES*LANE_W-1:0]     result
);
  localparam int HALF = LANES / 2;

  for (genvar j = 0; j < LANES; j++) begin : g_out
    logic [LANES*LANE_W-1:0] src;
    logic [LANE_W-1:0]       acc;
    if (j < HALF) begin : g_first
      assign src = opa;
    end else begin : g_second
      assign src = opb;
    end
    always_comb begin
      acc = '0;
      for (int k = 0; k < LANES; k++) begin
        if (sel_oh[j][k]) acc = acc | src[k*LANE_W +: LANE_W];
      end
    end
    assign result[j*LANE_W +: LANE_W] = acc;
  end
endmodule

// File: rtl/lane_shuffle_pipe.sv
module lane_shuffle_pipe #(
  parameter int DATA_W = 128,
  parameter int TAG_W  = 4,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [DATA_W-1:0] out_data
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst || flush) vld_q[i] <= 1'b0;
        else              vld_q[i] <= in_valid;
      end
      always_ff @(posedge clk) begin
        tag_q[i]  <= in_tag;
        data_q[i] <= in_data;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst || flush) vld_q[i] <= 1'b0;
        else              vld_q[i] <= vld_q[i-1];
      end
      always_ff @(posedge clk) begin
        tag_q[i]  <= tag_q[i-1];
        data_q[i] <= data_q[i-1];
      end
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_tag   = tag_q[DEPTH-1];
  assign out_data  = data_q[DEPTH-1];

  // cycles since the last clear, saturating at DEPTH
  logic [CNT_W-1:0] since_clear;
  always_ff @(posedge clk) begin
    if (rst || flush)                   since_clear <= '0;
    else if (since_clear != CNT_W'(DEPTH)) since_clear <= since_clear + 1'b1;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid) else $error("flush left a valid result"); // R8

  AST_NO_STALE_RESULT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (since_clear == CNT_W'(DEPTH))) else $error("result emerged too early after clear"); // R9
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit
  import lane_shuffle_pkg::*;
#(
  parameter int LANE_W  = DEF_LANE_W,
  parameter int LANES   = DEF_LANES,
  parameter int TAG_W   = DEF_TAG_W,
  parameter int LATENCY = DEF_LATENCY,
  localparam int SEL_W  = $clog2(LANES),
  localparam int CTRL_W = LANES * SEL_W,
  localparam int VEC_W  = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic [VEC_W-1:0]  in_opa,
  input  logic [VEC_W-1:0]  in_opb,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [VEC_W-1:0]  out_result
);
  localparam int HALF = LANES / 2;

  logic [LANES-1:0][LANES-1:0] sel_oh;
  logic [VEC_W-1:0]            shuf;

  lane_shuffle_decode #(.LANES(LANES), .SEL_W(SEL_W)) u_decode (
    .ctrl   (in_ctrl),
    .sel_oh (sel_oh)
  );

  lane_shuffle_mux #(.LANE_W(LANE_W), .LANES(LANES)) u_mux (
    .opa    (in_opa),
    .opb    (in_opb),
    .sel_oh (sel_oh),
    .result (shuf)
  );

  lane_shuffle_pipe #(.DATA_W(VEC_W), .TAG_W(TAG_W), .DEPTH(LATENCY)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_tag    (in_tag),
    .in_data   (shuf),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_data  (out_result)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_chk
    logic [LANES-1:0] hit;
    for (genvar k = 0; k < LANES; k++) begin : g_src
      if (j < HALF) begin : g_a
        assign hit[k] = (shuf[j*LANE_W +: LANE_W] == in_opa[k*LANE_W +: LANE_W]);
      end else begin : g_b
        assign hit[k] = (shuf[j*LANE_W +: LANE_W] == in_opb[k*LANE_W +: LANE_W]);
      end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      in_valid |-> $onehot(sel_oh[j])) else $error("lane index decode not one-hot"); // R1

    if (j < HALF) begin : g_low
      AST_LOW_FROM_FIRST: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (|hit)) else $error("low lane not taken from first operand"); // R2
    end else begin : g_high
      AST_HIGH_FROM_SECOND: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> (|hit)) else $error("high lane not taken from second operand"); // R3
    end
  end
endmodule

// File: tb/lane_shuffle_unit_tb.sv
module lane_shuffle_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 3;
  localparam int TAG_W      = 4;

  logic         clk, rst, flush, in_valid;
  logic [TAG_W-1:0] in_tag;
  logic [7:0]   in_ctrl;
  logic [127:0] in_opa, in_opb;
  logic         out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [127:0] out_result;

  lane_shuffle_unit #(.TAG_W(TAG_W), .LATENCY(LAT)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_tag(in_tag),
    .in_ctrl(in_ctrl), .in_opa(in_opa), .in_opb(in_opb),
    .out_valid(out_valid), .out_tag(out_tag), .out_result(out_result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  logic             hv [8];
  logic [TAG_W-1:0] ht [8];
  logic [127:0]     hd [8];
  string            hr [8];

  function automatic logic [127:0] ref_shuf(input logic [127:0] a, input logic [127:0] b,
                                            input logic [7:0] c);
    logic [127:0] r;
    r[31:0]   = a[32*c[1:0] +: 32];
    r[63:32]  = a[32*c[3:2] +: 32];
    r[95:64]  = b[32*c[5:4] +: 32];
    r[127:96] = b[32*c[7:6] +: 32];
    return r;
  endfunction

  task automatic check_out();
    int idx = (cyc + 8 - LAT) % 8;
    checks++;
    if (hv[idx]) begin
      if (!(out_valid === 1'b1 && out_tag === ht[idx] && out_result === hd[idx])) begin
        fails++;
        $display("FAIL %s: got v=%b tag=%h data=%h expected v=1 tag=%h data=%h",
                 hr[idx], out_valid, out_tag, out_result, ht[idx], hd[idx]);
      end
    end else if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL %s: got v=%b expected v=0", hr[idx], out_valid);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] c, input logic [127:0] a,
                      input logic [127:0] b, input logic fl, input string req,
                      input logic [127:0] exp);
    int idx;
    @(negedge clk);
    check_out();
    in_valid = v; in_ctrl = c; in_opa = a; in_opb = b; flush = fl;
    in_tag = TAG_W'(cyc);
    idx = cyc % 8;
    hv[idx] = v; ht[idx] = TAG_W'(cyc); hd[idx] = exp; hr[idx] = req;
    if (fl) for (int k = 0; k < LAT; k++) hv[(cyc + 8 - k) % 8] = 1'b0;
    cyc++;
  endtask

  task automatic op(input logic [7:0] c, input logic [127:0] a, input logic [127:0] b,
                    input string req);
    step(1'b1, c, a, b, 1'b0, req, ref_shuf(a, b, c));
  endtask

  task automatic idle(input string req);
    step(1'b0, $urandom, {4{$urandom}}, {4{$urandom}}, 1'b0, req, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; flush = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: reset got v=%b expected v=0", out_valid);
    end
    rst = 1'b0;
    for (int k = 0; k < 8; k++) hv[k] = 1'b0;
    cyc = 0;
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] a, b;
    rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_tag = '0; in_ctrl = '0;
    in_opa = '0; in_opb = '0;
    do_reset();

    // R1: field positions and lane numbering with distinct markers
    a = {32'hA3A3A3A3, 32'hA2A2A2A2, 32'hA1A1A1A1, 32'hA0A0A0A0};
    b = {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hB1B1B1B1, 32'hB0B0B0B0};
    step(1'b1, 8'hFF, a, b, 1'b0, "R1",
         {32'hB3B3B3B3, 32'hB3B3B3B3, 32'hA3A3A3A3, 32'hA3A3A3A3});
    step(1'b1, 8'h1B, a, b, 1'b0, "R1",
         {32'hB0B0B0B0, 32'hB1B1B1B1, 32'hA2A2A2A2, 32'hA3A3A3A3});
    step(1'b1, 8'hE4, a, b, 1'b0, "R1",
         {32'hB3B3B3B3, 32'hB2B2B2B2, 32'hA1A1A1A1, 32'hA0A0A0A0});

    // R2 R3 R6: all 256 control values back to back; R5: every fourth with equal operands
    for (int c = 0; c < 256; c++) begin
      a = rnd128();
      b = (c % 4 == 0) ? a : rnd128();
      op(8'(c), a, b, (c % 4 == 0) ? "R5" : ((c % 2) ? "R3" : "R2"));
    end

    // R4: special bit patterns
    a = {32'h80000000, 32'hFF800000, 32'h00000001, 32'h7FC00001};
    b = {32'h00000000, 32'hFFFFFFFF, 32'h807FFFFF, 32'h7F800001};
    op(8'h4E, a, b, "R4");
    op(8'hB1, a, b, "R4");
    op(8'h00, a, b, "R4");

    // R7: gaps with garbage inputs in idle cycles; R5: later input changes ignored
    for (int n = 0; n < 20; n++) begin
      if (n % 3 == 0) op($urandom, rnd128(), rnd128(), "R7");
      else idle("R7");
    end

    // R8: flush with an operation offered in the same cycle
    for (int n = 0; n < 5; n++) op($urandom, rnd128(), rnd128(), "R8");
    step(1'b1, $urandom, rnd128(), rnd128(), 1'b1, "R8", '0);
    for (int n = 0; n < 6; n++) op($urandom, rnd128(), rnd128(), "R8");
    step(1'b0, 8'h00, '0, '0, 1'b1, "R8", '0);
    for (int n = 0; n < LAT + 1; n++) idle("R8");

    // R9: reset in the middle of a stream
    for (int n = 0; n < 4; n++) op($urandom, rnd128(), rnd128(), "R9");
    do_reset();
    for (int n = 0; n < LAT + 1; n++) idle("R9");
    for (int n = 0; n < 4; n++) op($urandom, rnd128(), rnd128(), "R6");
    for (int n = 0; n < LAT + 1; n++) idle("R6");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule